// File: doc/BRIEF.md
# Byte-Serial Data FIFO Engine

This block sits between a word-wide system bus and a byte-wide card data port. It moves payload through a 16-entry FIFO of 32-bit words in either direction. In the receive direction, bytes arriving from the card are packed little-endian into words and pushed into the FIFO, where the bus pops them. In the transmit direction, the bus pushes words and the engine unpacks them one byte at a time toward the card.

A control write starts a transfer. It sets the direction and, when its enable bit is set, loads a 16-bit byte counter from the length input. The counter steps down by one for each byte that crosses the card port. When it runs out, a short final word is still delivered on receive, and any leftover bytes of the held word are discarded on transmit. Done bits are raised once the counter reaches zero. The engine switches itself off once both the counter and the FIFO are empty. A 22-bit status vector carries the done bits and one set of FIFO level flags, chosen by the direction.

Top module: `byte_fifo_engine`

## Requirements
- R1: After reset, dataEnable, byteCount, wordCount, statusFlags, busRdData, cardRxReady and cardTxValid are all zero.
- R2: In a cycle with ctrlWrite high, dataEnable takes ctrlEnable and the direction takes ctrlDirRx (1 = card to FIFO, 0 = FIFO to card). byteCount is loaded from lenValue only when ctrlEnable is 1 and is otherwise kept. Any partial packed word, the held transmit word and the done bits are cleared. Bus and card transfers offered in that same cycle are not taken.
- R3: The FIFO holds 16 words, returns them in push order across index wrap-around, and drops a push offered while it holds 16 words.
- R4: On receive, the first byte of a word lands in bits [7:0] and the fourth in bits [31:24]. The word is pushed when its fourth byte arrives.
- R5: On receive, the byte that brings byteCount to zero pushes the word collected so far, with the bytes not yet written set to zero.
- R6: cardRxReady is high only while enabled in the receive direction with byteCount nonzero and the FIFO not full. A byte offered while it is low is not taken.
- R7: On transmit, a word moves from the FIFO into the holding register only when the register is empty and no bus read is popping in that cycle. Its bytes go out lowest first, one per accepted cardTxValid/cardTxReady handshake. The bytes still held are discarded when byteCount reaches zero.
- R8: byteCount drops by exactly one per byte moved on the card port, and wordCount always equals (byteCount + 3) >> 2.
- R9: One clock after byteCount reads zero while enabled, status bits 8 and 10 are set. They stay set until the next control write.
- R10: Once byteCount is zero and the FIFO is empty while enabled, dataEnable clears on the next clock. While the byteCount-zero-and-FIFO-empty condition holds, or while disabled, status bits 12 to 21 are all zero.
- R11: While active in the receive direction, the status bits are: 13 = active, 15 = level at least 8, 17 = level 16, 19 = level 0, 21 = level nonzero. The transmit bits are zero.
- R12: While active in the transmit direction, the status bits are: 12 = active, 14 = level at most 8, 16 = level 16, 18 = level 0, 20 = level nonzero. The receive bits are zero.
- R13: A bus write is ignored while byteCount is zero, while the FIFO is full or while the direction is receive. A bus read of an empty FIFO returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWrite | input | 1 | Control write strobe |
| ctrlEnable | input | 1 | Enable bit of the control write |
| ctrlDirRx | input | 1 | Direction of the control write, 1 = card to FIFO |
| lenValue | input | 16 | Transfer length in bytes |
| busWrValid | input | 1 | Bus word push strobe |
| busWrData | input | 32 | Bus word to push |
| busRdReq | input | 1 | Bus word pop strobe |
| busRdData | output | 32 | FIFO head word, 0 when empty |
| cardRxValid | input | 1 | Card offers a received byte |
| cardRxData | input | 8 | Received byte |
| cardRxReady | output | 1 | Engine takes a received byte |
| cardTxValid | output | 1 | Engine offers a byte to send |
| cardTxData | output | 8 | Byte to send |
| cardTxReady | input | 1 | Card takes the offered byte |
| byteCount | output | 16 | Bytes left in the transfer |
| wordCount | output | 15 | Words left, rounded up |
| dataEnable | output | 1 | Data path enabled |
| statusFlags | output | 22 | Done bits and direction-dependent FIFO flags |

## Verification
On every cycle, the embedded properties check that the FIFO is never pushed when full or popped when empty, and that the bus and the transmit holding register never pop in the same cycle. They also check that each card-side byte takes exactly one count off the counter, that only one direction's flag set is ever lit, and that the done bits and the self-disable follow the counter reaching zero. The correctness of the data itself can only be shown by the bench's scenarios. That covers little-endian packing, zero fill of a short final word, the order of bytes leaving the holding register, the discarded tail, and words surviving pointer wrap-around. The same holds for pushes dropped at full occupancy and bus accesses that are ignored, since these are visible only as values the bus or card later does or does not see.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;

  // Strobes the control path hands to the datapath each cycle.
  typedef struct packed {
    logic restart;   // control write: clear packer and holding register
    logic rxTake;    // a card byte is accepted this cycle
    logic rxFlush;   // the packed word (with this byte) is pushed
    logic busPush;   // bus word is pushed
    logic busPop;    // head word is popped by the bus
    logic txLoad;    // head word moves into the holding register
    logic txTake;    // the card accepts the low held byte
    logic txDrop;    // remaining held bytes are discarded
  } moveCmd_t;

  localparam int FLAG_W      = 22;
  localparam int FLG_DONE    = 8;
  localparam int FLG_BLKDONE = 10;
  localparam int FLG_TX_ACT  = 12;
  localparam int FLG_RX_ACT  = 13;
  localparam int FLG_TX_HALF = 14;
  localparam int FLG_RX_HALF = 15;
  localparam int FLG_TX_FULL = 16;
  localparam int FLG_RX_FULL = 17;
  localparam int FLG_TX_MT   = 18;
  localparam int FLG_RX_MT   = 19;
  localparam int FLG_TX_AVL  = 20;
  localparam int FLG_RX_AVL  = 21;

endpackage

// File: rtl/byte_fifo_datapath.sv
module byte_fifo_datapath
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int BYTES  = WORD_W / 8,
  parameter int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  parameter int HOLD_W = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  moveCmd_t          cmd,
  input  logic [7:0]        rxByte,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic [7:0]        txByte,
  output logic [LVL_W-1:0]  level,
  output logic [IDX_W-1:0]  packIdx,
  output logic [HOLD_W-1:0] holdCount
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [WORD_W-1:0] packAcc, packWord, pushData, holdWord;
  logic              doPush, doPop;

  always_comb begin
    packWord = packAcc;
    for (int b = 0; b < BYTES; b++) begin
      if (packIdx == IDX_W'(b)) packWord[b*8 +: 8] = rxByte;
    end
  end

  assign doPush   = cmd.rxFlush | cmd.busPush;
  assign doPop    = cmd.busPop | cmd.txLoad;
  assign pushData = cmd.rxFlush ? packWord : busWrData;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      level <= level + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packAcc <= '0;
      packIdx <= '0;
    end else if (cmd.restart || cmd.rxFlush) begin
      packAcc <= '0;
      packIdx <= '0;
    end else if (cmd.rxTake) begin
      packAcc <= packWord;
      packIdx <= packIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord  <= '0;
      holdCount <= '0;
    end else if (cmd.restart) begin
      holdWord  <= '0;
      holdCount <= '0;
    end else if (cmd.txLoad) begin
      holdWord  <= mem[rdPtr];
      holdCount <= HOLD_W'(BYTES);
    end else if (cmd.txTake) begin
      holdWord  <= holdWord >> 8;
      holdCount <= cmd.txDrop ? '0 : holdCount - 1'b1;
    end
  end

  assign busRdData = (level != '0) ? mem[rdPtr] : '0;
  assign txByte    = holdWord[7:0];

  // R3: nothing is written into a full FIFO
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    doPush |-> (level != LVL_W'(DEPTH)));
  // R3: occupancy never exceeds the depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  // R13: no pop from an empty FIFO
  p_no_underflow_r13: assert property (@(posedge clk) disable iff (!rstN)
    doPop |-> (level != '0));
  // R7: bus and holding register never pop together
  p_single_reader_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.busPop && cmd.txLoad));

endmodule

// File: rtl/byte_fifo_control.sv
module byte_fifo_control
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int BYTES  = 4,
  parameter int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  parameter int HOLD_W = $clog2(BYTES + 1),
  parameter int WCNT_W = LEN_W + 1 - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic              ctrlEnable,
  input  logic              ctrlDirRx,
  input  logic [LEN_W-1:0]  lenValue,
  input  logic              busWrValid,
  input  logic              busRdReq,
  input  logic              cardRxValid,
  input  logic              cardTxReady,
  input  logic [LVL_W-1:0]  level,
  input  logic [IDX_W-1:0]  packIdx,
  input  logic [HOLD_W-1:0] holdCount,
  output moveCmd_t          cmd,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [LEN_W-1:0]  byteCount,
  output logic [WCNT_W-1:0] wordCount,
  output logic              dataEnable,
  output logic [FLAG_W-1:0] statusFlags
);

  logic dirRx, doneFlag, cntZero, fifoEmpty, fifoFull, active, go;
  logic [LEN_W:0] roundUp;

  assign cntZero   = (byteCount == '0);
  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level == LVL_W'(DEPTH));
  assign go        = !ctrlWrite;
  assign active    = dataEnable && !(cntZero && fifoEmpty);

  always_comb begin
    cardRxReady = go && dataEnable && dirRx && !cntZero && !fifoFull;
    cardTxValid = go && dataEnable && !dirRx && !cntZero && (holdCount != '0);
    cmd         = '0;
    cmd.restart = ctrlWrite;
    cmd.rxTake  = cardRxReady && cardRxValid;
    cmd.rxFlush = cmd.rxTake && ((packIdx == IDX_W'(BYTES - 1)) || (byteCount == LEN_W'(1)));
    cmd.txTake  = cardTxValid && cardTxReady;
    cmd.txDrop  = cmd.txTake && (byteCount == LEN_W'(1));
    cmd.busPop  = go && busRdReq && !fifoEmpty;
    cmd.busPush = go && busWrValid && !cntZero && !dirRx && !fifoFull;
    cmd.txLoad  = go && dataEnable && !dirRx && !cntZero && (holdCount == '0)
                  && !fifoEmpty && !cmd.busPop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataEnable <= 1'b0;
      dirRx      <= 1'b0;
      byteCount  <= '0;
      doneFlag   <= 1'b0;
    end else if (ctrlWrite) begin
      dataEnable <= ctrlEnable;
      dirRx      <= ctrlDirRx;
      if (ctrlEnable) byteCount <= lenValue;
      doneFlag   <= 1'b0;
    end else begin
      if (cmd.rxTake || cmd.txTake) byteCount <= byteCount - 1'b1;
      if (dataEnable && cntZero) doneFlag <= 1'b1;
      if (dataEnable && cntZero && fifoEmpty) dataEnable <= 1'b0;
    end
  end

  assign roundUp   = {1'b0, byteCount} + (LEN_W + 1)'(BYTES - 1);
  assign wordCount = WCNT_W'(roundUp >> IDX_W);

  always_comb begin
    statusFlags              = '0;
    statusFlags[FLG_DONE]    = doneFlag;
    statusFlags[FLG_BLKDONE] = doneFlag;
    if (active && dirRx) begin
      statusFlags[FLG_RX_ACT]  = 1'b1;
      statusFlags[FLG_RX_HALF] = level >= LVL_W'(DEPTH / 2);
      statusFlags[FLG_RX_FULL] = fifoFull;
      statusFlags[FLG_RX_MT]   = fifoEmpty;
      statusFlags[FLG_RX_AVL]  = !fifoEmpty;
    end else if (active) begin
      statusFlags[FLG_TX_ACT]  = 1'b1;
      statusFlags[FLG_TX_HALF] = level <= LVL_W'(DEPTH / 2);
      statusFlags[FLG_TX_FULL] = fifoFull;
      statusFlags[FLG_TX_MT]   = fifoEmpty;
      statusFlags[FLG_TX_AVL]  = !fifoEmpty;
    end
  end

  // R8: each card-side byte removes exactly one count
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rxTake || cmd.txTake) |=> (byteCount == $past(byteCount) - 1'b1));
  // R10: engine switches itself off once drained
  p_idle_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dataEnable && cntZero && fifoEmpty && !ctrlWrite) |=> !dataEnable);
  // R9: done bits follow the counter reaching zero
  p_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataEnable && cntZero && !ctrlWrite) |=> (statusFlags[FLG_DONE] && statusFlags[FLG_BLKDONE]));
  // R11 / R12: only one direction's flag set is ever lit
  p_one_side_r11: assert property (@(posedge clk) disable iff (!rstN)
    !((statusFlags[FLG_RX_ACT] || statusFlags[FLG_RX_MT] || statusFlags[FLG_RX_AVL])
      && (statusFlags[FLG_TX_ACT] || statusFlags[FLG_TX_MT] || statusFlags[FLG_TX_AVL])));

endmodule

// File: rtl/byte_fifo_engine.sv
module byte_fifo_engine
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  parameter int BYTES  = WORD_W / 8,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  parameter int HOLD_W = $clog2(BYTES + 1),
  parameter int WCNT_W = LEN_W + 1 - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic              ctrlEnable,
  input  logic              ctrlDirRx,
  input  logic [LEN_W-1:0]  lenValue,
  input  logic              busWrValid,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              busRdReq,
  output logic [WORD_W-1:0] busRdData,
  input  logic              cardRxValid,
  input  logic [7:0]        cardRxData,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [7:0]        cardTxData,
  input  logic              cardTxReady,
  output logic [LEN_W-1:0]  byteCount,
  output logic [WCNT_W-1:0] wordCount,
  output logic              dataEnable,
  output logic [FLAG_W-1:0] statusFlags
);

  moveCmd_t          cmd;
  logic [LVL_W-1:0]  level;
  logic [IDX_W-1:0]  packIdx;
  logic [HOLD_W-1:0] holdCount;

  byte_fifo_control #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .LVL_W(LVL_W), .BYTES(BYTES),
    .IDX_W(IDX_W), .HOLD_W(HOLD_W), .WCNT_W(WCNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable), .ctrlDirRx(ctrlDirRx),
    .lenValue(lenValue), .busWrValid(busWrValid), .busRdReq(busRdReq),
    .cardRxValid(cardRxValid), .cardTxReady(cardTxReady),
    .level(level), .packIdx(packIdx), .holdCount(holdCount),
    .cmd(cmd), .cardRxReady(cardRxReady), .cardTxValid(cardTxValid),
    .byteCount(byteCount), .wordCount(wordCount),
    .dataEnable(dataEnable), .statusFlags(statusFlags)
  );

  byte_fifo_datapath #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .LVL_W(LVL_W), .BYTES(BYTES),
    .IDX_W(IDX_W), .HOLD_W(HOLD_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rxByte(cardRxData), .busWrData(busWrData), .busRdData(busRdData),
    .txByte(cardTxData), .level(level), .packIdx(packIdx), .holdCount(holdCount)
  );

endmodule

// File: tb/byte_fifo_engine_tb.sv
`timescale 1ns/1ps
module byte_fifo_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrite, ctrlEnable, ctrlDirRx;
  logic [15:0] lenValue;
  logic        busWrValid, busRdReq;
  logic [31:0] busWrData, busRdData;
  logic        cardRxValid, cardRxReady, cardTxValid, cardTxReady;
  logic [7:0]  cardRxData, cardTxData;
  logic [15:0] byteCount;
  logic [14:0] wordCount;
  logic        dataEnable;
  logic [21:0] statusFlags;

  always #4 clk = ~clk;  // 125 MHz

  byte_fifo_engine u_dut (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
    .ctrlDirRx(ctrlDirRx), .lenValue(lenValue), .busWrValid(busWrValid),
    .busWrData(busWrData), .busRdReq(busRdReq), .busRdData(busRdData),
    .cardRxValid(cardRxValid), .cardRxData(cardRxData), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxData(cardTxData), .cardTxReady(cardTxReady),
    .byteCount(byteCount), .wordCount(wordCount), .dataEnable(dataEnable),
    .statusFlags(statusFlags)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mq[$];
  int          mCnt = 0;
  int          mIdx = 0;
  int          mHoldN = 0;
  bit          mEn = 0, mDir = 0, mDone = 0;
  logic [31:0] mAcc = 0, mHold = 0;

  function automatic logic [21:0] expFlags();
    logic [21:0] f = '0;
    int lvl = mq.size();
    f[8]  = mDone;
    f[10] = mDone;
    if (mEn && !(mCnt == 0 && lvl == 0)) begin
      if (mDir) begin
        f[13] = 1; f[15] = (lvl >= 8); f[17] = (lvl == 16); f[19] = (lvl == 0); f[21] = (lvl != 0);
      end else begin
        f[12] = 1; f[14] = (lvl <= 8); f[16] = (lvl == 16); f[18] = (lvl == 0); f[20] = (lvl != 0);
      end
    end
    return f;
  endfunction

  task automatic mReset();
    mq.delete();
    mCnt = 0; mIdx = 0; mHoldN = 0; mEn = 0; mDir = 0; mDone = 0; mAcc = 0; mHold = 0;
  endtask

  task automatic mStep();
    bit full, empty, cz, rxT, txT, popB, pushB, load, doneS, enC;
    logic [31:0] w, acc;
    full = (mq.size() == 16); empty = (mq.size() == 0); cz = (mCnt == 0);
    if (ctrlWrite) begin
      mEn = ctrlEnable; mDir = ctrlDirRx;
      if (ctrlEnable) mCnt = lenValue;
      mAcc = 0; mIdx = 0; mHoldN = 0; mHold = 0; mDone = 0;
      return;
    end
    rxT   = mEn && mDir && !cz && !full && cardRxValid;
    txT   = mEn && !mDir && !cz && (mHoldN != 0) && cardTxReady;
    popB  = busRdReq && !empty;
    pushB = busWrValid && !cz && !mDir && !full;
    load  = mEn && !mDir && !cz && (mHoldN == 0) && !empty && !popB;
    doneS = mEn && cz;
    enC   = mEn && cz && empty;
    if (popB || load) begin
      w = mq.pop_front();
      if (load) begin mHold = w; mHoldN = 4; end
    end
    if (txT) begin
      mHold  = mHold >> 8;
      mHoldN = (mCnt == 1) ? 0 : mHoldN - 1;
    end
    if (rxT) begin
      acc = mAcc | ({24'd0, cardRxData} << (8 * mIdx));
      if (mIdx == 3 || mCnt == 1) begin
        mq.push_back(acc); mAcc = 0; mIdx = 0;
      end else begin
        mAcc = acc; mIdx++;
      end
    end
    if (pushB) mq.push_back(busWrData);
    if (rxT || txT) mCnt--;
    if (doneS) mDone = 1;
    if (enC) mEn = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) mReset();
    else mStep();
  end

  // ---------------- per-cycle comparison ----------------
  logic [7:0] txGot[$];

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      bit eRx, eTx;
      eRx = !ctrlWrite && mEn && mDir && (mCnt != 0) && (mq.size() < 16);
      eTx = !ctrlWrite && mEn && !mDir && (mCnt != 0) && (mHoldN != 0);
      check("R6 cardRxReady", 32'(cardRxReady), 32'(eRx));
      check("R7 cardTxValid", 32'(cardTxValid), 32'(eTx));
      if (eTx) check("R7 cardTxData", 32'(cardTxData), 32'(mHold[7:0]));
      check("R13 busRdData", busRdData, (mq.size() != 0) ? mq[0] : 32'd0);
      check("R8 byteCount", 32'(byteCount), 32'(mCnt));
      check("R8 wordCount", 32'(wordCount), 32'((mCnt + 3) >> 2));
      check("R10 dataEnable", 32'(dataEnable), 32'(mEn));
      check("R11 R12 statusFlags", 32'(statusFlags), 32'(expFlags()));
      if (cardTxValid && cardTxReady) txGot.push_back(cardTxData);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFail++;
      $display("FAIL R7 watchdog got=%0d exp<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus tasks (entered and left at a falling edge) ----------------
  task automatic idleIn();
    ctrlWrite = 0; ctrlEnable = 0; ctrlDirRx = 0; lenValue = 0;
    busWrValid = 0; busWrData = 0; busRdReq = 0;
    cardRxValid = 0; cardRxData = 0; cardTxReady = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrl(input logic en, input logic dir, input logic [15:0] len);
    ctrlWrite = 1; ctrlEnable = en; ctrlDirRx = dir; lenValue = len;
    @(negedge clk);
    ctrlWrite = 0;
  endtask

  task automatic sendRx(input logic [7:0] b);
    cardRxValid = 1; cardRxData = b;
    #1;
    while (!cardRxReady) begin @(negedge clk); #1; end
    @(negedge clk);
    cardRxValid = 0;
  endtask

  task automatic pushWord(input logic [31:0] w);
    busWrValid = 1; busWrData = w;
    @(negedge clk);
    busWrValid = 0;
  endtask

  task automatic popWord(output logic [31:0] w);
    busRdReq = 1;
    #1 w = busRdData;
    @(negedge clk);
    busRdReq = 0;
  endtask

  initial begin
    logic [31:0] w;
    logic [7:0]  expB[$];
    idleIn();
    waitCyc(3);
    #1;
    check("R1 reset dataEnable", 32'(dataEnable), 0);
    check("R1 reset byteCount", 32'(byteCount), 0);
    check("R1 reset wordCount", 32'(wordCount), 0);
    check("R1 reset statusFlags", 32'(statusFlags), 0);
    check("R1 reset busRdData", busRdData, 0);
    check("R1 reset handshakes", 32'({cardRxReady, cardTxValid}), 0);
    @(negedge clk);
    rstN = 1;
    waitCyc(2);

    // ---- receive 10 bytes: two full words and a short one ----
    ctrl(1, 1, 16'd10);
    #1;
    check("R2 load count", 32'(byteCount), 10);
    check("R2 rx direction ready", 32'(cardRxReady), 1);
    @(negedge clk);
    for (int i = 0; i < 10; i++) sendRx(8'h11 + 8'(i));
    waitCyc(2);
    #1;
    check("R9 done bits", 32'({statusFlags[10], statusFlags[8]}), 32'h3);
    check("R10 stays enabled while FIFO holds data", 32'(dataEnable), 1);
    @(negedge clk);
    popWord(w); check("R4 little-endian word0", w, 32'h14131211);
    popWord(w); check("R4 little-endian word1", w, 32'h18171615);
    popWord(w); check("R5 short word zero fill", w, 32'h00001A19);
    waitCyc(2);
    #1;
    check("R10 disabled after drain", 32'(dataEnable), 0);
    check("R10 FIFO flags dropped", 32'(statusFlags), 32'h000500);
    @(negedge clk);
    popWord(w); check("R13 empty read returns 0", w, 0);

    // ---- receive until full, stall, wrap ----
    ctrl(1, 1, 16'd72);
    for (int i = 0; i < 64; i++) sendRx(8'(i));
    waitCyc(1);
    #1;
    check("R6 ready low when full", 32'(cardRxReady), 0);
    check("R11 full and half-full flags", 32'({statusFlags[17], statusFlags[15]}), 32'h3);
    @(negedge clk);
    cardRxValid = 1; cardRxData = 8'hEE;
    waitCyc(3);
    cardRxValid = 0;
    #1 check("R6 byte not taken while full", 32'(byteCount), 8);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      popWord(w);
      check("R3 FIFO order", w, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    end
    pushWord(32'hDEADBEEF);
    for (int k = 4; k < 16; k++) begin
      popWord(w);
      check("R3 R13 FIFO order, rx-side bus write ignored", w, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    end
    for (int i = 64; i < 72; i++) sendRx(8'(i));
    for (int k = 16; k < 18; k++) begin
      popWord(w);
      check("R3 order across wrap", w, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    end
    waitCyc(3);

    // ---- transmit 7 bytes from two words ----
    ctrl(1, 0, 16'd7);
    #1 check("R12 tx active, empty, half-empty", 32'({statusFlags[18], statusFlags[14], statusFlags[12]}), 32'h7);
    @(negedge clk);
    txGot.delete();
    cardTxReady = 1;
    pushWord(32'hA4A3A2A1);
    pushWord(32'hB4B3B2B1);
    waitCyc(16);
    cardTxReady = 0;
    expB = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2, 8'hB3};
    check("R7 tx byte total", 32'(txGot.size()), 7);
    for (int i = 0; i < 7 && i < txGot.size(); i++) check("R7 tx byte order", 32'(txGot[i]), 32'(expB[i]));
    #1 check("R10 tx disabled after tail drop", 32'(dataEnable), 0);
    @(negedge clk);
    pushWord(32'h12345678);
    popWord(w); check("R13 write with zero count ignored", w, 0);

    // ---- transmit: fill while card stalls, drop on full, drain ----
    ctrl(1, 0, 16'd80);
    for (int k = 0; k < 18; k++) pushWord(32'hC0000000 + 32'(k));
    #1 check("R12 tx full flag", 32'(statusFlags[16]), 1);
    @(negedge clk);
    txGot.delete();
    cardTxReady = 1;
    waitCyc(100);
    cardTxReady = 0;
    check("R3 dropped push: byte total", 32'(txGot.size()), 68);
    for (int i = 0; i < 68 && i < txGot.size(); i++) begin
      w = 32'hC0000000 + 32'(i / 4);
      check("R7 R3 drained byte", 32'(txGot[i]), 32'(w[8*(i%4) +: 8]));
    end
    #1 check("R8 remaining count", 32'(byteCount), 12);
    @(negedge clk);
    ctrl(0, 0, 16'd5);
    #1;
    check("R2 disable keeps count", 32'(byteCount), 12);
    check("R2 disable clears enable", 32'(dataEnable), 0);
    @(negedge clk);

    // ---- zero-length transfer ----
    ctrl(1, 0, 16'd0);
    waitCyc(2);
    #1;
    check("R9 zero length sets done", 32'(statusFlags[8]), 1);
    check("R10 zero length disables", 32'(dataEnable), 0);
    @(negedge clk);
    ctrl(0, 0, 16'd0);
    #1 check("R9 control write clears done", 32'(statusFlags[10]), 0);
    @(negedge clk);
    waitCyc(2);

    summary();
    $finish;
  end

endmodule